// File: doc/BRIEF.md
# USB Device Event Interrupt Controller

This block gathers the device-level events of a USB function and turns them into a single interrupt request for a small microcontroller. It watches eight sources. A bus reset is seen as a long single-ended zero on the line. Attach and detach come from an attach-sense level. Suspend entry and exit, completion of a control status stage, arrival of a setup packet and start of frame arrive as one-cycle pulses from neighbouring logic.

Each source has a sticky flag. A flag is set on its event whether or not that source is enabled. Software clears a flag by writing a one to its bit. An eight-bit enable register, readable on its own output, selects which flags may raise the request. The request also has two more enables above it: a device-interrupt enable and a global enable.

The single-ended zero is measured against a 12 MHz bit-tick input. Only an SE0 that lasts 30 ticks (2.5 µs) counts as a reset. The short SE0 that ends every packet is ignored.

Top module: `usb_dev_irq_ctrl`

## Requirements
- R1: The enable register reads 0x00 after reset. A write through the enable write port loads all eight bits, and the stored value is visible on the enable output from the following cycle. Bit map for enables and flags: 7 bus reset, 6 attach, 5 detach, 4 suspend entry, 3 suspend exit, 2 status stage done, 1 setup received, 0 start of frame.
- R2: After reset all flags read 0x00 and the request is low.
- R3: The bus-reset flag (bit 7) is set on the 30th bit tick counted while SE0 is continuously high. Any SE0 period shorter than 30 ticks sets nothing. The tick count restarts from zero whenever SE0 goes low.
- R4: A single continuous SE0 period sets the bus-reset flag at most once. If the flag is cleared while the same SE0 is still held, it stays clear however many further ticks arrive.
- R5: The attach-sense input is synchronized through two flops. A rising level sets the attach flag (bit 6) and a falling level sets the detach flag (bit 5), each exactly once per transition.
- R6: A one-cycle pulse on the suspend-entry, suspend-exit, status-done, setup or SOF input sets flag bit 4, 3, 2, 1 or 0 respectively at the next clock edge.
- R7: A flag is set by its event even when its enable bit is 0.
- R8: Writing the flag-clear port clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R9: If a flag's event and a clear of that flag land in the same cycle, the flag ends up set.
- R10: The request is registered. It equals the OR over the eight sources of flag AND enable, ANDed with the device enable and the global enable, and it follows its inputs one clock later.
- R11: A set flag whose enable bit is 0 does not raise the request. Removing either the device enable or the global enable drops the request one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle pulse at the 12 MHz bit rate |
| se0_i | input | 1 | Line is in single-ended zero |
| attach_lvl_i | input | 1 | Attach-sense level (asynchronous) |
| susp_enter_i | input | 1 | Pulse: suspend entered |
| susp_exit_i | input | 1 | Pulse: suspend left |
| status_done_i | input | 1 | Pulse: control status stage finished |
| setup_rx_i | input | 1 | Pulse: setup packet received |
| sof_i | input | 1 | Pulse: start of frame |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| clr_wr_i | input | 1 | Flag clear write strobe |
| clr_wdata_i | input | 8 | Flag clear mask, one clears |
| dev_irq_en_i | input | 1 | Device-interrupt enable |
| glob_irq_en_i | input | 1 | Global interrupt enable |
| en_o | output | 8 | Enable register contents |
| flags_o | output | 8 | Sticky event flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The SE0 qualifier is driven with a 29-tick SE0, an interrupted SE0 whose two parts each stay below the limit, an exact 30-tick SE0, and an SE0 held far past the limit with the flag cleared partway. Together these separate an off-by-one threshold, a counter that fails to restart, and a repeated event. Each pulse source is fired alone, with its enable both clear and set, to show the bit mapping and that flags ignore the enables. The request is then checked against every gating level one at a time, and a clear is made to collide with an event to show which one wins.

// File: rtl/usb_irq_pkg.sv
// Package: shared bit positions and sizes for the USB device event
// interrupt controller. Assumes eight sources in a fixed bit order.
package usb_irq_pkg;
    localparam int NUM_EV      = 8;
    localparam int EV_BUSRST   = 7;
    localparam int EV_ATTACH   = 6;
    localparam int EV_DETACH   = 5;
    localparam int EV_SUSP_IN  = 4;
    localparam int EV_SUSP_OUT = 3;
    localparam int EV_STATUS   = 2;
    localparam int EV_SETUP    = 1;
    localparam int EV_SOF      = 0;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/se0_reset_qual.sv
// Module: se0_reset_qual
// Counts bit ticks while SE0 is held. Emits a one-cycle event on the
// tick that reaches TICK_LIMIT, then holds until SE0 drops.
// Assumes se0_i is already synchronous to clk.
module se0_reset_qual #(
    parameter int TICK_LIMIT = 30,
    localparam int CNT_W     = $clog2(TICK_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic se0_i,
    input  logic tick_i,
    output logic busrst_evt_o
);
    logic [CNT_W-1:0] tick_cnt_q;
    logic             at_limit;

    assign at_limit     = (tick_cnt_q == CNT_W'(TICK_LIMIT));
    // Event on the tick that would bring the count to the limit
    assign busrst_evt_o = se0_i && tick_i && (tick_cnt_q == CNT_W'(TICK_LIMIT - 1));

    // Duration counter: clears when SE0 drops, saturates at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (!se0_i) begin
            tick_cnt_q <= '0;
        end else if (tick_i && !at_limit) begin
            tick_cnt_q <= tick_cnt_q + CNT_W'(1);
        end
    end

    // R3
    // cnt_restart_chk
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !se0_i |=> (tick_cnt_q == '0));

    // R4
    // cnt_bound_chk
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt_q <= CNT_W'(TICK_LIMIT));

    // R4
    // one_evt_chk
    one_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busrst_evt_o |=> (!busrst_evt_o && (!se0_i || at_limit)) || !se0_i);
endmodule

// File: rtl/attach_edge_det.sv
// Module: attach_edge_det
// Brings the asynchronous attach-sense level into the clk domain with a
// SYNC_STAGES flop chain, then reports rising (attach) and falling
// (detach) edges as one-cycle pulses. Assumes the level is low at reset.
module attach_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic attach_evt_o,
    output logic detach_evt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   lvl_s;

    assign lvl_s = sync_q[SYNC_STAGES-1];

    // Synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], lvl_i};
        end
    end

    // Delayed copy of the synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= lvl_s;
        end
    end

    assign attach_evt_o = lvl_s && !last_q;
    assign detach_evt_o = !lvl_s && last_q;

    // R5
    // edge_excl_chk
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attach_evt_o |=> !attach_evt_o);
endmodule

// File: rtl/irq_event_bank.sv
// Module: irq_event_bank
// Holds the enable register and the sticky per-event flags, and forms
// the registered interrupt request. Set beats write-one-to-clear.
// Assumes all event inputs are single-cycle pulses in the clk domain.
module irq_event_bank
    import usb_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ev_vec_t evt_i,
    input  logic    en_wr_i,
    input  ev_vec_t en_wdata_i,
    input  logic    clr_wr_i,
    input  ev_vec_t clr_wdata_i,
    input  logic    dev_en_i,
    input  logic    glob_en_i,
    output ev_vec_t en_o,
    output ev_vec_t flags_o,
    output logic    irq_o
);
    ev_vec_t en_q;
    ev_vec_t flags_q;
    ev_vec_t clr_mask;
    logic    irq_q;

    assign clr_mask = clr_wr_i ? clr_wdata_i : '0;

    // Enable register: plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr_i) begin
            en_q <= en_wdata_i;
        end
    end

    // One sticky flag per source, set has priority over clear
    for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[g] <= 1'b0;
            end else if (evt_i[g]) begin
                flags_q[g] <= 1'b1;
            end else if (clr_mask[g]) begin
                flags_q[g] <= 1'b0;
            end
        end
    end

    // Registered request through the three enable levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (|(flags_q & en_q)) && dev_en_i && glob_en_i;
        end
    end

    assign en_o    = en_q;
    assign flags_o = flags_q;
    assign irq_o   = irq_q;

    // R1
    // en_reset_chk
    en_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0));

    // R7
    // R9
    // flag_set_chk
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

    // R8
    // flag_hold_chk
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask)));

    // R11
    // irq_gate_chk
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_en_i && glob_en_i) |=> !irq_o);

    // R11
    // irq_mask_chk
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & en_q) == '0) |=> !irq_o);
endmodule

// File: rtl/usb_dev_irq_ctrl.sv
// Module: usb_dev_irq_ctrl
// Top of the USB device event interrupt controller. Qualifies SE0 by
// duration, edge-detects attach sense, and feeds all eight events into
// the flag/enable bank. Assumes pulse inputs last one clk cycle.
module usb_dev_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter int SE0_TICKS   = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick_i,
    input  logic       se0_i,
    input  logic       attach_lvl_i,
    input  logic       susp_enter_i,
    input  logic       susp_exit_i,
    input  logic       status_done_i,
    input  logic       setup_rx_i,
    input  logic       sof_i,
    input  logic       en_wr_i,
    input  logic [7:0] en_wdata_i,
    input  logic       clr_wr_i,
    input  logic [7:0] clr_wdata_i,
    input  logic       dev_irq_en_i,
    input  logic       glob_irq_en_i,
    output logic [7:0] en_o,
    output logic [7:0] flags_o,
    output logic       irq_o
);
    logic    busrst_evt;
    logic    attach_evt;
    logic    detach_evt;
    ev_vec_t evt_vec;

    se0_reset_qual #(.TICK_LIMIT(SE0_TICKS)) i_se0_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .se0_i        (se0_i),
        .tick_i       (bit_tick_i),
        .busrst_evt_o (busrst_evt)
    );

    attach_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_attach_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_i        (attach_lvl_i),
        .attach_evt_o (attach_evt),
        .detach_evt_o (detach_evt)
    );

    // Gather the event pulses into the fixed bit order
    always_comb begin
        evt_vec              = '0;
        evt_vec[EV_BUSRST]   = busrst_evt;
        evt_vec[EV_ATTACH]   = attach_evt;
        evt_vec[EV_DETACH]   = detach_evt;
        evt_vec[EV_SUSP_IN]  = susp_enter_i;
        evt_vec[EV_SUSP_OUT] = susp_exit_i;
        evt_vec[EV_STATUS]   = status_done_i;
        evt_vec[EV_SETUP]    = setup_rx_i;
        evt_vec[EV_SOF]      = sof_i;
    end

    irq_event_bank i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_vec),
        .en_wr_i     (en_wr_i),
        .en_wdata_i  (en_wdata_i),
        .clr_wr_i    (clr_wr_i),
        .clr_wdata_i (clr_wdata_i),
        .dev_en_i    (dev_irq_en_i),
        .glob_en_i   (glob_irq_en_i),
        .en_o        (en_o),
        .flags_o     (flags_o),
        .irq_o       (irq_o)
    );

    // R10
    // irq_follow_chk
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags_o & en_o) != '0) && dev_irq_en_i && glob_irq_en_i
        && $past(dev_irq_en_i && glob_irq_en_i) |-> irq_o);
endmodule

// File: tb/test_usb_dev_irq_ctrl.sv
// Directed bench for usb_dev_irq_ctrl. Inputs change on the falling
// edge and outputs are sampled on the falling edge.
module test_usb_dev_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick_i, se0_i, attach_lvl_i;
    logic       susp_enter_i, susp_exit_i, status_done_i, setup_rx_i, sof_i;
    logic       en_wr_i, clr_wr_i, dev_irq_en_i, glob_irq_en_i;
    logic [7:0] en_wdata_i, clr_wdata_i;
    logic [7:0] en_o, flags_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_dev_irq_ctrl i_usb_dev_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick_i), .se0_i(se0_i),
        .attach_lvl_i(attach_lvl_i), .susp_enter_i(susp_enter_i),
        .susp_exit_i(susp_exit_i), .status_done_i(status_done_i),
        .setup_rx_i(setup_rx_i), .sof_i(sof_i), .en_wr_i(en_wr_i),
        .en_wdata_i(en_wdata_i), .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i),
        .dev_irq_en_i(dev_irq_en_i), .glob_irq_en_i(glob_irq_en_i),
        .en_o(en_o), .flags_o(flags_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_en(input logic [7:0] v);
        en_wr_i = 1'b1; en_wdata_i = v; step(1);
        en_wr_i = 1'b0; en_wdata_i = '0;
    endtask

    task automatic clear_flags(input logic [7:0] m);
        clr_wr_i = 1'b1; clr_wdata_i = m; step(1);
        clr_wr_i = 1'b0; clr_wdata_i = '0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick_i = 1'b1; step(1);
            bit_tick_i = 1'b0; step(1);
        end
    endtask

    task automatic pulse(input int idx);
        case (idx)
            4: susp_enter_i  = 1'b1;
            3: susp_exit_i   = 1'b1;
            2: status_done_i = 1'b1;
            1: setup_rx_i    = 1'b1;
            default: sof_i   = 1'b1;
        endcase
        step(1);
        {susp_enter_i, susp_exit_i, status_done_i, setup_rx_i, sof_i} = '0;
    endtask

    task automatic t_reset();
        chk("R1 enable after reset", en_o, 8'h00);
        chk("R2 flags after reset", flags_o, 8'h00);
        chk("R2 irq after reset", {7'b0, irq_o}, 8'h00);
        write_en(8'hA5);
        chk("R1 enable readback", en_o, 8'hA5);
        write_en(8'h00);
        chk("R1 enable cleared", en_o, 8'h00);
    endtask

    task automatic t_se0();
        se0_i = 1'b1; tick(29);
        chk("R3 29 ticks no reset flag", flags_o, 8'h00);
        se0_i = 1'b0; step(2);
        se0_i = 1'b1; tick(20);
        chk("R3 count restarted", flags_o, 8'h00);
        se0_i = 1'b0; step(2);
        se0_i = 1'b1; tick(30);
        chk("R3 30 ticks sets bit7", flags_o, 8'h80);
        clear_flags(8'h80);
        chk("R8 bit7 cleared", flags_o, 8'h00);
        tick(40);
        chk("R4 no second event in same SE0", flags_o, 8'h00);
        se0_i = 1'b0; step(2);
    endtask

    task automatic t_attach();
        attach_lvl_i = 1'b1; step(4);
        chk("R5 attach sets bit6", flags_o, 8'h40);
        clear_flags(8'hFF); step(3);
        chk("R5 attach once", flags_o, 8'h00);
        attach_lvl_i = 1'b0; step(4);
        chk("R5 detach sets bit5", flags_o, 8'h20);
        clear_flags(8'hFF);
    endtask

    task automatic t_pulses();
        for (int i = 0; i <= 4; i++) begin
            pulse(i);
            chk("R6 R7 pulse sets flag with enable 0", flags_o, 8'(1 << i));
            clear_flags(8'hFF);
        end
        pulse(4); pulse(2); pulse(0);
        clear_flags(8'h04);
        chk("R8 only masked bit cleared", flags_o, 8'h11);
        clear_flags(8'hFF);
    endtask

    task automatic t_collide();
        pulse(1);
        sof_i = 1'b1; setup_rx_i = 1'b1; clr_wr_i = 1'b1; clr_wdata_i = 8'h03;
        step(1);
        sof_i = 1'b0; setup_rx_i = 1'b0; clr_wr_i = 1'b0; clr_wdata_i = '0;
        chk("R9 set wins over clear", flags_o, 8'h03);
        clear_flags(8'hFF);
    endtask

    task automatic t_irq();
        dev_irq_en_i = 1'b1; glob_irq_en_i = 1'b1;
        pulse(2); step(2);
        chk("R11 disabled source no irq", {7'b0, irq_o}, 8'h00);
        write_en(8'h04);
        chk("R10 irq not yet (registered)", {7'b0, irq_o}, 8'h00);
        step(1);
        chk("R10 irq raised", {7'b0, irq_o}, 8'h01);
        glob_irq_en_i = 1'b0; step(1);
        chk("R11 global enable gates irq", {7'b0, irq_o}, 8'h00);
        glob_irq_en_i = 1'b1; step(1);
        chk("R10 irq back", {7'b0, irq_o}, 8'h01);
        dev_irq_en_i = 1'b0; step(1);
        chk("R11 device enable gates irq", {7'b0, irq_o}, 8'h00);
        dev_irq_en_i = 1'b1; step(1);
        clear_flags(8'h04);
        chk("R10 irq lags flag clear", {7'b0, irq_o}, 8'h01);
        step(1);
        chk("R10 irq drops after clear", {7'b0, irq_o}, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0;
        {bit_tick_i, se0_i, attach_lvl_i} = '0;
        {susp_enter_i, susp_exit_i, status_done_i, setup_rx_i, sof_i} = '0;
        {en_wr_i, clr_wr_i, dev_irq_en_i, glob_irq_en_i} = '0;
        en_wdata_i = '0; clr_wdata_i = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_se0();
        t_attach();
        t_pulses();
        t_collide();
        t_irq();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule